// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used page translations close to the processor. Each slot holds a virtual page number and the page table entry image that belongs to it. A lookup compares the requested page number against every slot at once. The result comes back on the next clock edge: a hit returns the stored entry image and the physical address, and a miss tells the external table walker to fetch the entry. The walker then installs the fetched image through a refill command. When every slot is occupied, the slot whose last use is oldest is replaced.

Software keeps the cache consistent with two maintenance commands. One removes a single page after its table entry has been changed. The other empties the whole cache, for example on an address-space switch. A hit sets the reference bit in the cached image, and a write hit also sets the modify bit. When a slot leaves the cache carrying bits that differ from the image it was loaded with, its page number and current image are presented once so that the table in memory can be updated.

Top module: `xlat_lookaside`

## Requirements
- R1: A lookup request (`lk_valid`=1) produces exactly one of `res_hit` or `res_miss` in the following cycle. Neither is raised in a cycle that follows a cycle without a request.
- R2: On a hit, `res_paddr` equals the frame field of the returned image (bits 31..12) followed by the request offset `lk_off` in bits 11..0.
- R3: Image bit 1 is the reference bit and bit 2 is the modify bit. A hit returns the stored image with bit 1 set, and with bit 2 also set when `lk_wr`=1. The updated image stays in the slot.
- R4: A refill installs `rf_vpn` with the image `rf_pte`, so that later lookups of that page hit. A refill of a page that is already cached replaces that slot's image and creates no second copy.
- R5: A lookup is judged against the contents held before its own cycle, so a refill of the same page in the same cycle does not make that lookup hit.
- R6: A refill takes an empty slot while one exists and then evicts nothing. When the cache is full, it replaces the page whose last hit or refill is oldest. The choice is made from the usage order held before any lookup in the same cycle.
- R7: An invalidate removes only the slot that holds `inv_vpn`, and an invalidate of an absent page changes nothing. A refill in the same cycle as an invalidate is discarded.
- R8: A flush empties every slot. It takes priority over an invalidate or a refill in the same cycle and produces no write-back report.
- R9: When an eviction, an invalidate or a same-page refill displaces a slot whose reference or modify bit was set after loading, `wb_valid` is high for one cycle in the next cycle, with that slot's page number and current image. A displaced slot with no such change produces no report.
- R10: After reset all slots are empty and every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_wr | input | 1 | The lookup is for a write access |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_off | input | 12 | Byte offset within the page |
| rf_valid | input | 1 | Refill command from the walker |
| rf_vpn | input | 20 | Page number to install |
| rf_pte | input | 32 | Entry image to install |
| inv_valid | input | 1 | Invalidate-one-page command |
| inv_vpn | input | 20 | Page number to invalidate |
| flush | input | 1 | Empty the whole cache |
| res_hit | output | 1 | The previous lookup hit |
| res_miss | output | 1 | The previous lookup missed |
| res_pte | output | 32 | Entry image returned on a hit |
| res_paddr | output | 32 | Physical address returned on a hit |
| wb_valid | output | 1 | A displaced slot needs write-back |
| wb_vpn | output | 20 | Page number of the displaced slot |
| wb_pte | output | 32 | Current image of the displaced slot |

## Verification
The properties assume that the command strobes are known levels sampled at the rising edge. They also assume that `lk_off` means something only in a cycle with `lk_valid` high. No property depends on the walker's image content, because the reference bit the block sets is the only image bit that any property checks. The stimulus changes every input on the falling edge. It returns the strobes to zero between commands, except in the deliberate same-cycle pairings: refill with lookup, refill with invalidate, and refill with flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VPN_W_DEF   = 20;
    parameter int OFF_W_DEF   = 12;
    parameter int PTE_W_DEF   = 32;
    parameter int DEPTH_DEF   = 8;
    // Status bit positions inside an entry image
    parameter int PTE_REF_BIT = 1;
    parameter int PTE_MOD_BIT = 2;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int DEPTH = 8,
    parameter int KEY_W = 20,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]            probe,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = vld[g] && (keys[g] == probe);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0][IDX_W-1:0] age,
    output logic [IDX_W-1:0]            idx
);
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(DEPTH - 1);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (age[i] == AGE_MAX) old_idx = IDX_W'(i);
        end
        idx = any_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/xlat_lookaside.sv
module xlat_lookaside
    import xlat_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int VPN_W = VPN_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int PTE_W = PTE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_wr,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PTE_W-1:0] rf_pte,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush,
    output logic             res_hit,
    output logic             res_miss,
    output logic [PTE_W-1:0] res_pte,
    output logic [PTE_W-1:0] res_paddr,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic [PTE_W-1:0] wb_pte
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [PTE_W-1:0] REF_MASK = PTE_W'(1) << PTE_REF_BIT;
    localparam logic [PTE_W-1:0] MOD_MASK = PTE_W'(1) << PTE_MOD_BIT;

    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0]            chg;
        logic [DEPTH-1:0][VPN_W-1:0] vpn;
        logic [DEPTH-1:0][PTE_W-1:0] pte;
        logic [DEPTH-1:0][IDX_W-1:0] age;
        logic                        hit;
        logic                        miss;
        logic [PTE_W-1:0]            rpte;
        logic [PTE_W-1:0]            paddr;
        logic                        wb;
        logic [VPN_W-1:0]            wbvpn;
        logic [PTE_W-1:0]            wbpte;
    } state_t;

    state_t q, d;

    logic             lk_hit, rf_hit, inv_hit;
    logic [IDX_W-1:0] lk_idx, rf_idx, inv_idx, vic_idx, slot;
    logic [PTE_W-1:0] npte;

    // Parallel compare for each of the three page-number probes
    xlat_cam #(.DEPTH(DEPTH), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_lk (
        .vld(q.vld), .keys(q.vpn), .probe(lk_vpn), .hit(lk_hit), .idx(lk_idx));
    xlat_cam #(.DEPTH(DEPTH), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_rf (
        .vld(q.vld), .keys(q.vpn), .probe(rf_vpn), .hit(rf_hit), .idx(rf_idx));
    xlat_cam #(.DEPTH(DEPTH), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_inv (
        .vld(q.vld), .keys(q.vpn), .probe(inv_vpn), .hit(inv_hit), .idx(inv_idx));

    xlat_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
        .vld(q.vld), .age(q.age), .idx(vic_idx));

    // Make slot k youngest; slots younger than k age by one
    function automatic logic [DEPTH-1:0][IDX_W-1:0] touch(
        input logic [DEPTH-1:0][IDX_W-1:0] a, input logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] ak;
        ak    = a[k];
        touch = a;
        for (int i = 0; i < DEPTH; i++) begin
            if (a[i] < ak) touch[i] = a[i] + 1'b1;
        end
        touch[k] = '0;
    endfunction

    always_comb begin
        d       = q;
        d.hit   = 1'b0;
        d.miss  = 1'b0;
        d.rpte  = '0;
        d.paddr = '0;
        d.wb    = 1'b0;
        d.wbvpn = '0;
        d.wbpte = '0;
        npte    = q.pte[lk_idx] | REF_MASK | (lk_wr ? MOD_MASK : '0);
        slot    = rf_hit ? rf_idx : vic_idx;

        if (lk_valid) begin
            if (lk_hit) begin
                if (npte != q.pte[lk_idx]) d.chg[lk_idx] = 1'b1;
                d.pte[lk_idx] = npte;
                d.age         = touch(q.age, lk_idx);
                d.hit         = 1'b1;
                d.rpte        = npte;
                d.paddr       = {npte[PTE_W-1:OFF_W], lk_off};
            end else begin
                d.miss = 1'b1;
            end
        end

        if (flush) begin
            d.vld = '0;
            d.chg = '0;
        end else if (inv_valid) begin
            if (inv_hit) begin
                if (d.chg[inv_idx]) begin
                    d.wb    = 1'b1;
                    d.wbvpn = d.vpn[inv_idx];
                    d.wbpte = d.pte[inv_idx];
                end
                d.vld[inv_idx] = 1'b0;
                d.chg[inv_idx] = 1'b0;
            end
        end else if (rf_valid) begin
            if (d.vld[slot] && d.chg[slot]) begin
                d.wb    = 1'b1;
                d.wbvpn = d.vpn[slot];
                d.wbpte = d.pte[slot];
            end
            d.vld[slot] = 1'b1;
            d.chg[slot] = 1'b0;
            d.vpn[slot] = rf_vpn;
            d.pte[slot] = rf_pte;
            d.age       = touch(d.age, slot);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < DEPTH; i++) q.age[i] <= IDX_W'(i);
        end else begin
            q <= d;
        end
    end

    assign res_hit   = q.hit;
    assign res_miss  = q.miss;
    assign res_pte   = q.rpte;
    assign res_paddr = q.paddr;
    assign wb_valid  = q.wb;
    assign wb_vpn    = q.wbvpn;
    assign wb_pte    = q.wbpte;
endmodule

// File: rtl/xlat_lookaside_chk.sv
module xlat_lookaside_chk #(
    parameter int OFF_W = 12,
    parameter int FRM_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [OFF_W-1:0] lk_off,
    input logic             inv_valid,
    input logic             rf_valid,
    input logic             flush,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_ref,
    input logic [FRM_W-1:0] res_frame,
    input logic [FRM_W-1:0] paddr_frame,
    input logic [OFF_W-1:0] paddr_off,
    input logic             wb_valid,
    input logic             wb_ref
);
    logic flush_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush;
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_hit && res_miss));                                         // R1
    AST_RESULT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit || res_miss) |-> $past(lk_valid));                      // R1
    AST_REQ_GETS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit || res_miss));                             // R1
    AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> paddr_off == $past(lk_off));                         // R2
    AST_PADDR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> paddr_frame == res_frame);                           // R2
    AST_HIT_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_ref);                                            // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && lk_valid) |=> !res_hit);                             // R8
    AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(inv_valid || rf_valid) && !$past(flush)));   // R9
    AST_WB_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_ref);                                            // R9
endmodule

bind xlat_lookaside xlat_lookaside_chk #(.OFF_W(OFF_W), .FRM_W(PTE_W - OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_off     (lk_off),
    .inv_valid  (inv_valid),
    .rf_valid   (rf_valid),
    .flush      (flush),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_ref    (res_pte[xlat_pkg::PTE_REF_BIT]),
    .res_frame  (res_pte[PTE_W-1:OFF_W]),
    .paddr_frame(res_paddr[PTE_W-1:OFF_W]),
    .paddr_off  (res_paddr[OFF_W-1:0]),
    .wb_valid   (wb_valid),
    .wb_ref     (wb_pte[xlat_pkg::PTE_REF_BIT])
);

// File: tb/test_xlat_lookaside.sv
module test_xlat_lookaside;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_wr = 0, rf_valid = 0, inv_valid = 0, flush = 0;
    logic [19:0] lk_vpn = '0, rf_vpn = '0, inv_vpn = '0;
    logic [11:0] lk_off = '0;
    logic [31:0] rf_pte = '0;
    logic        res_hit, res_miss, wb_valid;
    logic [31:0] res_pte, res_paddr, wb_pte;
    logic [19:0] wb_vpn;

    always #2.5 clk = ~clk;

    xlat_lookaside i_xlat_lookaside (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_wr(lk_wr),
        .lk_vpn(lk_vpn), .lk_off(lk_off), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
        .rf_pte(rf_pte), .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush),
        .res_hit(res_hit), .res_miss(res_miss), .res_pte(res_pte),
        .res_paddr(res_paddr), .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_pte(wb_pte));

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    typedef struct { bit hit; logic [31:0] pte; logic [31:0] paddr; int due; string tag; } res_t;
    typedef struct { logic [19:0] vpn; logic [31:0] pte; int due; string tag; } wb_t;
    res_t res_q[$];
    wb_t  wb_q[$];

    // Reference model: a set of cached pages with last-use times
    bit          m_vld[N];
    logic [19:0] m_vpn[N];
    logic [31:0] m_pte[N];
    bit          m_chg[N];
    int          m_t[N];
    int          now = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int find(input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_hit || res_miss) begin
                if (res_q.size() == 0) begin
                    chk(0, "R1", "unexpected result", {62'd0, res_hit, res_miss}, 64'd0);
                end else begin
                    res_t e;
                    e = res_q.pop_front();
                    chk(res_hit == e.hit && res_miss == !e.hit, e.tag, "hit/miss",
                        {63'd0, res_hit}, {63'd0, e.hit});
                    if (e.hit) begin
                        chk(res_pte == e.pte, e.tag, "entry image", {32'd0, res_pte}, {32'd0, e.pte});
                        chk(res_paddr == e.paddr, e.tag, "physical address",
                            {32'd0, res_paddr}, {32'd0, e.paddr});
                    end
                end
            end else if (res_q.size() != 0 && res_q[0].due <= cyc) begin
                res_t e;
                e = res_q.pop_front();
                chk(0, e.tag, "missing result", 64'd0, 64'd1);
            end
            if (wb_valid) begin
                if (wb_q.size() == 0) begin
                    chk(0, "R9", "unexpected write-back", {44'd0, wb_vpn}, 64'd0);
                end else begin
                    wb_t w;
                    w = wb_q.pop_front();
                    chk(wb_vpn == w.vpn && wb_pte == w.pte, w.tag, "write-back vpn/image",
                        {12'd0, wb_vpn, wb_pte}, {12'd0, w.vpn, w.pte});
                end
            end else if (wb_q.size() != 0 && wb_q[0].due <= cyc) begin
                wb_t w;
                w = wb_q.pop_front();
                chk(0, w.tag, "missing write-back", 64'd0, {12'd0, w.vpn, w.pte});
            end
        end
    end

    // Driver: applies one cycle of commands and predicts the outcome
    task automatic step(input bit lk, input logic [19:0] lv, input logic [11:0] lo, input bit lw,
                        input bit rf, input logic [19:0] rv, input logic [31:0] rp,
                        input bit iv, input logic [19:0] ivv, input bit fl, input string tag);
        int vic, j, cnt, s;
        @(negedge clk);
        lk_valid = lk; lk_vpn = lv; lk_off = lo; lk_wr = lw;
        rf_valid = rf; rf_vpn = rv; rf_pte = rp;
        inv_valid = iv; inv_vpn = ivv; flush = fl;
        // victim from the order before this cycle's lookup
        vic = -1; cnt = 0;
        for (int i = 0; i < N; i++) if (m_vld[i]) cnt++;
        if (cnt < N) begin
            for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) vic = i;
        end else begin
            vic = 0;
            for (int i = 1; i < N; i++) if (m_t[i] < m_t[vic]) vic = i;
        end
        if (lk) begin
            res_t e;
            e.due = cyc + 1; e.tag = tag;
            j = find(lv);
            if (j >= 0) begin
                logic [31:0] np;
                np = m_pte[j] | 32'h2 | (lw ? 32'h4 : 32'h0);
                if (np != m_pte[j]) m_chg[j] = 1;
                m_pte[j] = np; m_t[j] = now;
                e.hit = 1; e.pte = np; e.paddr = {np[31:12], lo};
            end else begin
                e.hit = 0; e.pte = '0; e.paddr = '0;
            end
            res_q.push_back(e);
        end
        if (fl) begin
            for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_chg[i] = 0; end
        end else if (iv) begin
            j = find(ivv);
            if (j >= 0) begin
                if (m_chg[j]) wb_q.push_back('{m_vpn[j], m_pte[j], cyc + 1, tag});
                m_vld[j] = 0; m_chg[j] = 0;
            end
        end else if (rf) begin
            j = find(rv);
            s = (j >= 0) ? j : vic;
            if (m_vld[s] && m_chg[s]) wb_q.push_back('{m_vpn[s], m_pte[s], cyc + 1, tag});
            m_vld[s] = 1; m_chg[s] = 0; m_vpn[s] = rv; m_pte[s] = rp; m_t[s] = now;
        end
        now++;
    endtask

    task automatic look(input logic [19:0] v, input logic [11:0] o, input bit w, input string tag);
        step(1, v, o, w, 0, '0, '0, 0, '0, 0, tag);
    endtask
    task automatic fill(input logic [19:0] v, input logic [31:0] p, input string tag);
        step(0, '0, '0, 0, 1, v, p, 0, '0, 0, tag);
    endtask
    task automatic kill(input logic [19:0] v, input string tag);
        step(0, '0, '0, 0, 0, '0, '0, 1, v, 0, tag);
    endtask
    task automatic idle();
        step(0, '0, '0, 0, 0, '0, '0, 0, '0, 0, "idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_chg[i] = 0; m_t[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!res_hit && !res_miss && !wb_valid && res_pte == 0 && res_paddr == 0, "R10",
            "outputs after reset", {res_hit, res_miss, wb_valid}, 64'd0);
        look(20'h00010, 12'h000, 0, "R10");
        // R2 R3 R4: install and hit
        fill(20'h12345, 32'h0101_0001, "R4");
        look(20'h12345, 12'h678, 0, "R2");
        look(20'h12345, 12'h001, 1, "R3");
        // R5: same-cycle refill and lookup of one page
        step(1, 20'h00B00, 12'h010, 0, 1, 20'h00B00, 32'h0B00_0001, 0, '0, 0, "R5");
        look(20'h00B00, 12'h020, 0, "R5");
        // R6: fill the remaining free slots, no eviction
        for (int i = 0; i < 6; i++) fill(20'h20000 + 20'(i), 32'h2000_0001 + (i << 12), "R6");
        look(20'h12345, 12'h002, 0, "R6");
        fill(20'h2AAAA, 32'h2AAA_A001, "R9");   // evicts the oldest page 00B00
        look(20'h00B00, 12'h030, 0, "R6");
        look(20'h20001, 12'h040, 0, "R6");
        // R4: same-page refill replaces the image
        fill(20'h12345, 32'h0AAA_A001, "R4");
        look(20'h12345, 12'h050, 0, "R4");
        // R7: invalidate one page
        kill(20'h20003, "R7");
        look(20'h20003, 12'h060, 0, "R7");
        look(20'h20004, 12'h070, 0, "R7");
        kill(20'h7FFFF, "R7");
        look(20'h20005, 12'h080, 0, "R7");
        look(20'h2AAAA, 12'h090, 1, "R7");
        step(0, '0, '0, 0, 1, 20'h30000, 32'h3000_0001, 1, 20'h12345, 0, "R7");
        look(20'h30000, 12'h0A0, 0, "R7");
        look(20'h12345, 12'h0B0, 0, "R7");
        // R9: image loaded with reference bit already set, read hit changes nothing
        fill(20'h30001, 32'h0030_0003, "R9");
        look(20'h30001, 12'h0C0, 0, "R9");
        kill(20'h30001, "R9");
        // R8: flush beats a same-cycle refill
        step(0, '0, '0, 0, 1, 20'h40000, 32'h4000_0001, 0, '0, 1, "R8");
        look(20'h40000, 12'h0D0, 0, "R8");
        look(20'h2AAAA, 12'h0E0, 0, "R8");
        look(20'h20000, 12'h0F0, 0, "R8");
        // R6: refill past capacity after the flush
        for (int i = 0; i < 9; i++) fill(20'h50000 + 20'(i), 32'h5000_0001 + (i << 12), "R6");
        look(20'h50000, 12'h100, 0, "R6");
        look(20'h50008, 12'h110, 0, "R6");
        look(20'h50001, 12'h120, 1, "R6");
        repeat (3) idle();
        @(negedge clk);
        chk(res_q.size() == 0, "R1", "pending results", res_q.size(), 0);
        chk(wb_q.size() == 0, "R9", "pending write-backs", wb_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule